// File: doc/BRIEF.md
# Line-Crossing Load Splitter

This block sits between a load/store pipeline stage and a data-cache request port. It takes a load given as a byte address and a size of 1 to 8 bytes. It decides whether the bytes fall inside one cache line or spill into the next one.

A load that stays inside one line goes out as one cache request with part tag 0. A load that crosses a line boundary goes out as two line-local requests, tagged 0 and 1. The two parts may return in either order, and their bytes are collected into a merge buffer. Once every expected part is back, the block presents one result carrying the original address and size. A store that would cross a line is refused and flagged, and no store is ever sent to the cache.

The controller has five states:
- IDLE: ready for a new request.
- PART0: offers the first, or only, request.
- PART1: offers the second-line request.
- WAIT: collects responses.
- DONE: presents the result for one cycle.

Its transitions are:
- IDLE to PART0 on an accepted load.
- PART0 to PART1 on a handshake of a crossing load.
- PART0 to WAIT on a handshake of a single-part load.
- PART1 to WAIT on its handshake.
- WAIT to DONE when the part count reaches the number expected.
- DONE back to IDLE.

An accepted store leaves the block in IDLE. Only one load is in flight at a time.

Top module: `lsplit_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `cache_req_valid`, `res_valid` and `store_err` are 0.
- R2: A load that does not cross a line issues exactly one cache request with tag 0, the request address, and the request size.
- R3: The second-line address is the address of the last byte (`addr + size - 1`) rounded down to a multiple of `LINE_BYTES`. A load counts as crossing only when that address is strictly greater than `addr`.
- R4: A crossing load issues two requests, in this order. The first is tag 0 at `addr` with size `second - addr`. The second is tag 1 at `second` with size `addr + size - second`.
- R5: In the result, byte lane i (bits 8i+7..8i) holds the following. For i below the first part's size, it is lane i of the tag-0 response. From that offset up to the total size, it is lane (i - first size) of the tag-1 response. Lanes at or beyond the total size are 0. Response lanes beyond a part's size are ignored.
- R6: The result of a crossing load is the same whichever order the two tagged responses arrive in.
- R7: `res_valid` rises only after all expected parts have returned. It lasts one cycle and comes with the original address and size.
- R8: A store with `req_is_store` = 1 that crosses a line pulses `store_err` for one cycle, in the cycle after it is accepted. It issues no cache request.
- R9: A store that stays in one line produces no cache request, no error and no result.
- R10: `req_ready` is 0 while a load is in flight. A cache request held back by `cache_req_ready` = 0 keeps its address, size and tag stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pipeline request present |
| req_ready | output | 1 | Block can take a request (IDLE) |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | SZ_W | Access size in bytes, 1..DATA_BYTES |
| req_is_store | input | 1 | Access is a store |
| cache_req_valid | output | 1 | Cache request offered |
| cache_req_ready | input | 1 | Cache takes the request |
| cache_req_addr | output | ADDR_W | Line-local request address |
| cache_req_size | output | SZ_W | Part size in bytes |
| cache_req_tag | output | 1 | Part index, 0 or 1 |
| cache_rsp_valid | input | 1 | Cache response present |
| cache_rsp_tag | input | 1 | Part index echoed by the cache |
| cache_rsp_data | input | 8*DATA_BYTES | Response bytes, lane 0 = requested address |
| res_valid | output | 1 | Assembled result present |
| res_addr | output | ADDR_W | Original load address |
| res_size | output | SZ_W | Original load size |
| res_data | output | 8*DATA_BYTES | Assembled bytes, upper lanes zero |
| store_err | output | 1 | Line-crossing store refused |

## Verification
The hardest situation to reach from the ports is a crossing load whose tag-1 response arrives before its tag-0 response. The cache model also has to fill the lanes beyond each part's size with live data, because only then does a bad merge offset or missing mask show up. The bench uses a small 16-byte line and sweeps every start offset in the line against every size from 1 to 8. Every crossing case runs twice, once with responses in issue order and once reversed. Every third offset also throttles `cache_req_ready` to hold requests back. Each response lane comes from a fixed byte function of its address, so the expected result is pure arithmetic.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PART0,
        ST_PART1,
        ST_WAIT,
        ST_DONE
    } lsplit_state_e;

endpackage

// File: rtl/lsplit_calc.sv
// Boundary detection and part address/size computation.
module lsplit_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SZ_W       = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    output logic [ADDR_W-1:0] second_addr,
    output logic              crosses,
    output logic [SZ_W-1:0]   size0,
    output logic [SZ_W-1:0]   size1
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        last_byte   = addr + ADDR_W'(size) - ADDR_W'(1);
        second_addr = last_byte & ~LINE_MASK;
        crosses     = second_addr > addr;
        // distance is below the access size, so low bits suffice
        size0       = crosses ? (second_addr[SZ_W-1:0] - addr[SZ_W-1:0]) : size;
        size1       = crosses ? (size - size0) : '0;
    end
endmodule

// File: rtl/lsplit_merge.sv
// Merge buffer: places each tagged part at its own byte offset.
module lsplit_merge #(
    parameter int DATA_BYTES = 8,
    parameter int SZ_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic                    rsp_tag,
    input  logic [8*DATA_BYTES-1:0] rsp_data,
    input  logic [SZ_W-1:0]         size0,
    input  logic [SZ_W-1:0]         size1,
    output logic [8*DATA_BYTES-1:0] merged,
    output logic [1:0]              parts_done
);
    localparam int DW = 8 * DATA_BYTES;

    logic [SZ_W-1:0] part_sz;
    logic [SZ_W-1:0] part_off;
    logic [DW-1:0]   kept;
    logic [DW-1:0]   placed;

    always_comb begin
        part_sz  = rsp_tag ? size1 : size0;
        part_off = rsp_tag ? size0 : '0;
        for (int i = 0; i < DATA_BYTES; i++) begin
            kept[i*8 +: 8] = (SZ_W'(i) < part_sz) ? rsp_data[i*8 +: 8] : 8'h00;
        end
        placed = kept << {part_off, 3'b000};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged     <= '0;
            parts_done <= '0;
        end else if (clear) begin
            merged     <= '0;
            parts_done <= '0;
        end else if (take) begin
            merged     <= merged | placed;
            parts_done <= parts_done + 2'd1;
        end
    end
endmodule

// File: rtl/lsplit_top.sv
module lsplit_top #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int DATA_BYTES = 8,
    parameter int SZ_W       = $clog2(DATA_BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [SZ_W-1:0]         req_size,
    input  logic                    req_is_store,
    output logic                    cache_req_valid,
    input  logic                    cache_req_ready,
    output logic [ADDR_W-1:0]       cache_req_addr,
    output logic [SZ_W-1:0]         cache_req_size,
    output logic                    cache_req_tag,
    input  logic                    cache_rsp_valid,
    input  logic                    cache_rsp_tag,
    input  logic [8*DATA_BYTES-1:0] cache_rsp_data,
    output logic                    res_valid,
    output logic [ADDR_W-1:0]       res_addr,
    output logic [SZ_W-1:0]         res_size,
    output logic [8*DATA_BYTES-1:0] res_data,
    output logic                    store_err
);
    import lsplit_pkg::*;

    lsplit_state_e state_q, state_d;

    logic [ADDR_W-1:0] calc_second;
    logic              calc_cross;
    logic [SZ_W-1:0]   calc_s0, calc_s1;

    logic [ADDR_W-1:0] addr_q, second_q;
    logic [SZ_W-1:0]   size_q, s0_q, s1_q;
    logic              split_q, err_q;

    logic              accept_load, accept_store, take_rsp;
    logic [1:0]        parts_done, parts_need;

    lsplit_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SZ_W(SZ_W)) u_calc (
        .addr        (req_addr),
        .size        (req_size),
        .second_addr (calc_second),
        .crosses     (calc_cross),
        .size0       (calc_s0),
        .size1       (calc_s1)
    );

    assign accept_load  = (state_q == ST_IDLE) && req_valid && !req_is_store;
    assign accept_store = (state_q == ST_IDLE) && req_valid && req_is_store;
    assign parts_need   = split_q ? 2'd2 : 2'd1;
    assign take_rsp     = cache_rsp_valid && (parts_done < parts_need) &&
                          ((state_q == ST_PART1) || (state_q == ST_WAIT));

    lsplit_merge #(.DATA_BYTES(DATA_BYTES), .SZ_W(SZ_W)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept_load),
        .take       (take_rsp),
        .rsp_tag    (cache_rsp_tag),
        .rsp_data   (cache_rsp_data),
        .size0      (s0_q),
        .size1      (s1_q),
        .merged     (res_data),
        .parts_done (parts_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_load) state_d = ST_PART0;
            ST_PART0: if (cache_req_ready) state_d = split_q ? ST_PART1 : ST_WAIT;
            ST_PART1: if (cache_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (parts_done == parts_need) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            second_q <= '0;
            size_q   <= '0;
            s0_q     <= '0;
            s1_q     <= '0;
            split_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= accept_store && calc_cross;
            if (accept_load) begin
                addr_q   <= req_addr;
                second_q <= calc_second;
                size_q   <= req_size;
                s0_q     <= calc_s0;
                s1_q     <= calc_s1;
                split_q  <= calc_cross;
            end
        end
    end

    always_comb begin
        req_ready       = (state_q == ST_IDLE);
        cache_req_valid = (state_q == ST_PART0) || (state_q == ST_PART1);
        cache_req_tag   = (state_q == ST_PART1);
        cache_req_addr  = (state_q == ST_PART1) ? second_q : addr_q;
        cache_req_size  = (state_q == ST_PART1) ? s1_q : s0_q;
        res_valid       = (state_q == ST_DONE);
        res_addr        = addr_q;
        res_size        = size_q;
        store_err       = err_q;
    end
endmodule

// File: rtl/lsplit_chk.sv
module lsplit_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SZ_W       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cache_req_valid,
    input logic              cache_req_ready,
    input logic [ADDR_W-1:0] cache_req_addr,
    input logic [SZ_W-1:0]   cache_req_size,
    input logic              cache_req_tag,
    input logic              res_valid,
    input logic              store_err
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    // R10: pipeline sees busy while a cache request is offered
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid |-> !req_ready);

    // R10: stalled request holds its fields
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req_valid && !cache_req_ready) |=>
        (cache_req_valid && $stable(cache_req_addr) &&
         $stable(cache_req_size) && $stable(cache_req_tag)));

    // R4: every part stays inside one line
    a_r4_line_local: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid |->
        (int'(cache_req_addr[OFF_W-1:0]) + int'(cache_req_size) <= LINE_BYTES));

    // R2: no empty part is ever requested
    a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req_valid |-> (cache_req_size != '0));

    // R7: one-cycle result pulse, not overlapping a request
    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r7_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cache_req_valid);

    // R8: error is a single-cycle pulse
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        store_err |=> !store_err);
endmodule

bind lsplit_top lsplit_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SZ_W(SZ_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_ready       (req_ready),
    .cache_req_valid (cache_req_valid),
    .cache_req_ready (cache_req_ready),
    .cache_req_addr  (cache_req_addr),
    .cache_req_size  (cache_req_size),
    .cache_req_tag   (cache_req_tag),
    .res_valid       (res_valid),
    .store_err       (store_err)
);

// File: tb/sim_lsplit_top.sv
module sim_lsplit_top;
    localparam int AW = 32;
    localparam int LB = 16;
    localparam int DB = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_is_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic          cache_req_ready = 1'b0;
    logic          cache_rsp_valid = 1'b0, cache_rsp_tag = 1'b0;
    logic [63:0]   cache_rsp_data = '0;
    logic          req_ready, cache_req_valid, cache_req_tag, res_valid, store_err;
    logic [AW-1:0] cache_req_addr, res_addr;
    logic [SW-1:0] cache_req_size, res_size;
    logic [63:0]   res_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    lsplit_top #(.ADDR_W(AW), .LINE_BYTES(LB), .DATA_BYTES(DB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_is_store(req_is_store),
        .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
        .cache_req_addr(cache_req_addr), .cache_req_size(cache_req_size),
        .cache_req_tag(cache_req_tag),
        .cache_rsp_valid(cache_rsp_valid), .cache_rsp_tag(cache_rsp_tag),
        .cache_rsp_data(cache_rsp_data),
        .res_valid(res_valid), .res_addr(res_addr), .res_size(res_size),
        .res_data(res_data), .store_err(store_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    function automatic logic [63:0] lanes(input logic [AW-1:0] a);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = mb(a + AW'(i));
        return r;
    endfunction

    task automatic run_load(input logic [AW-1:0] a, input int sz, input bit rev,
                            input bit slow);
        logic [AW-1:0] sec, pa0, pa1, qa0, qa1;
        int            s0, need, n, q0s, q1s, q0t, q1t, k;
        bit            sp, seen;
        logic [63:0]   expd;
        sec  = (a + AW'(sz) - 1) & ~AW'(LB - 1);
        sp   = sec > a;
        s0   = sp ? int'(sec - a) : sz;
        need = sp ? 2 : 1;
        expd = '0;
        for (int i = 0; i < 8; i++) if (i < sz) expd[i*8 +: 8] = mb(a + AW'(i));
        pa0 = a;
        pa1 = sec;
        qa0 = '0; qa1 = '0; q0s = 0; q1s = 0; q0t = 0; q1t = 0;

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = SW'(sz); req_is_store = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 busy", 64'(req_ready), 64'd0);
        n = 0;
        for (int j = 0; j < 40 && n < need; j++) begin
            cache_req_ready = slow ? j[0] : 1'b1;
            #0.1;
            if (cache_req_valid && cache_req_ready) begin
                if (n == 0) begin qa0 = cache_req_addr; q0s = int'(cache_req_size); q0t = int'(cache_req_tag); end
                else        begin qa1 = cache_req_addr; q1s = int'(cache_req_size); q1t = int'(cache_req_tag); end
                n++;
            end
            @(negedge clk);
        end
        cache_req_ready = 1'b0;
        chk(n == need, sp ? "R3 split count" : "R2 single count", 64'(n), 64'(need));
        chk(qa0 == pa0 && q0s == s0 && q0t == 0, sp ? "R4 part0" : "R2 request",
            {qa0, 24'(q0s), 8'(q0t)}, {pa0, 24'(s0), 8'd0});
        if (sp)
            chk(qa1 == pa1 && q1s == sz - s0 && q1t == 1, "R4 part1",
                {qa1, 24'(q1s), 8'(q1t)}, {pa1, 24'(sz - s0), 8'd1});

        for (int j = 0; j < need; j++) begin
            int t;
            t = rev ? (need - 1 - j) : j;
            cache_rsp_valid = 1'b1;
            cache_rsp_tag   = t[0];
            cache_rsp_data  = lanes(t == 1 ? pa1 : pa0);
            @(negedge clk);
            cache_rsp_valid = 1'b0;
            if (sp && j == 0) begin
                seen = 1'b0;
                for (int w = 0; w < 3; w++) begin
                    if (res_valid) seen = 1'b1;
                    @(negedge clk);
                end
                chk(!seen, "R7 early result", 64'(seen), 64'd0);
            end
        end
        k = 0;
        while (!res_valid && k < 20) begin @(negedge clk); k++; end
        chk(res_valid == 1'b1, "R7 result arrives", 64'(res_valid), 64'd1);
        chk(res_data == expd, rev ? "R6 reversed merge" : "R5 merge", res_data, expd);
        chk(res_addr == a && int'(res_size) == sz, "R7 addr/size",
            {res_addr, 32'(res_size)}, {a, 32'(sz)});
        @(negedge clk);
        chk(res_valid == 1'b0, "R7 one-cycle", 64'(res_valid), 64'd0);
    endtask

    task automatic run_store(input logic [AW-1:0] a, input int sz);
        bit cr, bad;
        cr = ((a + AW'(sz) - 1) & ~AW'(LB - 1)) > a;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = SW'(sz); req_is_store = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_is_store = 1'b0;
        chk(store_err == cr, cr ? "R8 store error" : "R9 no store error",
            64'(store_err), 64'(cr));
        bad = 1'b0;
        for (int w = 0; w < 4; w++) begin
            if (cache_req_valid || res_valid) bad = 1'b1;
            if (w > 0 && store_err) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, cr ? "R8 no request" : "R9 no request", 64'(bad), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && cache_req_valid == 1'b0 && res_valid == 1'b0 &&
            store_err == 1'b0, "R1 reset state",
            {60'd0, req_ready, cache_req_valid, res_valid, store_err}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        for (int off = 0; off < LB; off++) begin
            for (int sz = 1; sz <= DB; sz++) begin
                logic [AW-1:0] a;
                a = 32'h0000_1240 + AW'(off);
                run_load(a, sz, 1'b0, (off % 3) == 0);
                if (off + sz > LB) run_load(a, sz, 1'b1, (off % 3) == 1);
            end
        end
        for (int off = 8; off < LB; off++) begin
            run_store(32'h0000_2000 + AW'(off), 8);
            run_store(32'h0000_2000 + AW'(off), 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule